// File: doc/BRIEF.md
# DMA Channel Service Engine

This block is the transfer sequencer that sits behind a four-channel DMA register file. It keeps, per channel, a request flag driven by pulses from the peripheral, a current address loaded from the programmed base, and a running count of transferred bytes. On every clock it serves at most one channel that is unmasked, requesting and not yet finished. It emits a full physical memory address and a transfer strobe, and it raises a one-cycle terminal-count pulse when the programmed length has been moved.

The upper address bits come from two sets of per-channel page registers (a page byte and a high page byte). Both sets are written and read through a small port whose offsets map onto channels by a fixed, non-linear table. A width-shift parameter scales both the starting address and the length. With a shift of 0 the engine serves a byte controller. With a shift of 1 it serves a word controller, where each service moves one 16-bit word.

The register decoding that produces the base, count, mode and mask inputs is outside this block, and so is the memory data path.

Top module: `dma_service_engine`

## Requirements
- R1: After reset the strobe and all terminal-count bits are 0, no channel is requesting, and every page and high page register reads 0.
- R2: A page port offset (3 bits) selects the channel as 7→0, 3→1, 1→2, 2→3. `pg_wr_hi_i`/`pg_rd_hi_i` = 1 selects the high page register and 0 the page register. A read returns the full 8-bit value last written.
- R3: Page port offsets 0, 4, 5 and 6 select no channel: writes there change no register, and reads there return 0.
- R4: The transfer address is {high_page[6:0], page[7:0], offset[15:0]} of the served channel. Bit 7 of the high page register never reaches the address.
- R5: A `hold_i` pulse sets the channel's request, and a `release_i` pulse clears it. When both arrive in the same cycle, hold wins. A hold on a finished channel restarts it with count 0.
- R6: A channel is served only when its `mask_i` bit is 0, its request is set, it is not finished, and its `load_i` bit is 0. Among eligible channels the lowest index wins, and one channel is served per cycle.
- R7: A `load_i` pulse sets the current address to (base address << SHIFT), truncated to 16 bits. It clears the count and the finished state.
- R8: Each service advances the count by 1 << SHIFT. The offset of that service is current address + count when `dec_i` is 0, and current address − count when `dec_i` is 1 (modulo 2^16), using the count before the advance.
- R9: When the advanced count equals (base count + 1) << SHIFT, bit ch of `tc_o` is 1 in the same cycle as that service's strobe and 0 in the next cycle. The channel is then finished and no longer served.
- R10: With `auto_i` = 1, terminal count sets the count back to 0 and the channel stays eligible, so the next service restarts at the current address.
- R11: With SHIFT = 1 the current address is base × 2, the offset steps by 2 per service, and terminal count comes after base count + 1 services.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_wr_i | input | 1 | Page register write enable |
| pg_wr_hi_i | input | 1 | Write targets the high page (1) or page (0) |
| pg_wr_port_i | input | 3 | Page port offset for the write |
| pg_wr_data_i | input | 8 | Page write data |
| pg_rd_hi_i | input | 1 | Read targets the high page (1) or page (0) |
| pg_rd_port_i | input | 3 | Page port offset for the read |
| pg_rd_data_o | output | 8 | Combinational page read data |
| base_addr_i | input | 4*OFF_W | Per-channel base address, channel 0 in the low bits |
| base_cnt_i | input | 4*OFF_W | Per-channel base count (length − 1) |
| dec_i | input | 4 | Per-channel decrement mode |
| auto_i | input | 4 | Per-channel auto-initialise |
| mask_i | input | 4 | Per-channel mask, 1 blocks service |
| load_i | input | 4 | Per-channel reprogram pulse |
| hold_i | input | 4 | Per-channel request hold pulse |
| release_i | input | 4 | Per-channel request release pulse |
| xfer_o | output | 1 | One transfer this cycle |
| xfer_chan_o | output | 2 | Channel of the transfer |
| xfer_addr_o | output | 7+8+OFF_W | Physical address of the transfer |
| tc_o | output | 4 | One-cycle terminal-count pulse per channel |

## Verification
Every cycle, the assertions check these properties:
- at most one channel is granted, and only an eligible one;
- a finished channel is never served;
- terminal count never appears without a strobe and lasts a single cycle outside auto-initialise;
- hold and release pulses leave the request flag in the state they demand.

The address arithmetic, the scrambled page map, the ignored invalid ports, the decrement wrap-around, the mask gating, the auto-initialise restart and the word-controller scaling can be shown only by the bench's scenarios. A scoreboard there compares every strobe against the transfer sequence predicted from the programmed values.

// File: rtl/dma_svc_pkg.sv
// Package: shared constants and the page-port decode for the DMA service engine.
// Assumes exactly four channels; the port map is fixed by the system, not a parameter.
package dma_svc_pkg;

    localparam int NCH       = 4;
    localparam int CH_W      = 2;
    localparam int PORT_W    = 3;
    localparam int PAGE_W    = 8;
    localparam int HPAGE_USE = 7;

    typedef struct packed {
        logic            ok;
        logic [CH_W-1:0] ch;
    } port_map_t;

    // Decode a page port offset to a channel; offsets 0,4,5,6 are not mapped.
    function automatic port_map_t map_port(input logic [PORT_W-1:0] p);
        port_map_t m;
        m = '0;
        case (p)
            3'd1:    begin m.ok = 1'b1; m.ch = 2'd2; end
            3'd2:    begin m.ok = 1'b1; m.ch = 2'd3; end
            3'd3:    begin m.ok = 1'b1; m.ch = 2'd1; end
            3'd7:    begin m.ok = 1'b1; m.ch = 2'd0; end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dma_page_regs.sv
// Module: per-channel page and high page registers behind a scrambled port map.
// Assumes single-cycle writes; reads are combinational and return 0 on unmapped ports.
module dma_page_regs
    import dma_svc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic                  wr_hi_i,
    input  logic [PORT_W-1:0]     wr_port_i,
    input  logic [PAGE_W-1:0]     wr_data_i,
    input  logic                  rd_hi_i,
    input  logic [PORT_W-1:0]     rd_port_i,
    output logic [PAGE_W-1:0]     rd_data_o,
    output logic [NCH*PAGE_W-1:0] page_o,
    output logic [NCH*PAGE_W-1:0] hpage_o
);

    logic [PAGE_W-1:0] page_q  [NCH];
    logic [PAGE_W-1:0] hpage_q [NCH];
    port_map_t         wmap;
    port_map_t         rmap;

    assign wmap = map_port(wr_port_i);
    assign rmap = map_port(rd_port_i);

    // Store a write into the decoded channel's page or high page register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                page_q[i]  <= '0;
                hpage_q[i] <= '0;
            end
        end else if (wr_en_i && wmap.ok) begin
            if (wr_hi_i) hpage_q[wmap.ch] <= wr_data_i;
            else         page_q[wmap.ch]  <= wr_data_i;
        end
    end

    // Return the addressed register, or zero for an unmapped offset.
    always_comb begin
        rd_data_o = '0;
        if (rmap.ok) rd_data_o = rd_hi_i ? hpage_q[rmap.ch] : page_q[rmap.ch];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_flat
        assign page_o[g*PAGE_W +: PAGE_W]  = page_q[g];
        assign hpage_o[g*PAGE_W +: PAGE_W] = hpage_q[g];
    end

endmodule

// File: rtl/dma_chan_state.sv
// Module: state of one DMA channel: request flag, current address, transferred count.
// Assumes serve_i is only asserted when want_o is high and load_i is low.
module dma_chan_state #(
    parameter  int OFF_W = 16,
    parameter  int SHIFT = 0,
    localparam int CNT_W = OFF_W + SHIFT + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             hold_i,
    input  logic             release_i,
    input  logic             serve_i,
    input  logic             auto_i,
    input  logic [OFF_W-1:0] base_addr_i,
    input  logic [OFF_W-1:0] base_cnt_i,
    output logic             want_o,
    output logic [OFF_W-1:0] cur_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tc_hit_o
);

    localparam logic [CNT_W-1:0] UNIT = CNT_W'(1) << SHIFT;

    logic             req_q;
    logic             done_q;
    logic [OFF_W-1:0] cur_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] cnt_adv;

    assign len      = (CNT_W'(base_cnt_i) + CNT_W'(1)) << SHIFT;
    assign cnt_adv  = cnt_q + UNIT;
    assign tc_hit_o = serve_i && (cnt_adv == len);
    assign want_o   = req_q && !done_q;
    assign cur_o    = cur_q;
    assign cnt_o    = cnt_q;

    // Track the peripheral request; hold has priority over release.
    always_ff @(posedge clk) begin
        if (!rst_n)         req_q <= 1'b0;
        else if (hold_i)    req_q <= 1'b1;
        else if (release_i) req_q <= 1'b0;
    end

    // Reload, advance or restart the count and finished state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (load_i) begin
            cur_q  <= OFF_W'(CNT_W'(base_addr_i) << SHIFT);
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (serve_i) begin
            if (tc_hit_o && auto_i) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_adv;
                if (tc_hit_o) done_q <= 1'b1;
            end
        end else if (hold_i && done_q) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end
    end

    AST_HOLD_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> req_q);                                                 // R5
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !hold_i) |=> !req_q);                                // R5
    AST_DONE_NOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !serve_i);                                              // R9

endmodule

// File: rtl/dma_fixed_arb.sv
// Module: fixed-priority picker, lowest index wins.
// Assumes a purely combinational use; the caller registers the result.
module dma_fixed_arb #(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          valid_o
);

    // Scan from the top down so the lowest requesting index is kept last.
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IW'(i);
                valid_o    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_service_engine.sv
// Module: DMA channel service engine. Picks one eligible channel per cycle,
// emits its physical address with a strobe, and pulses terminal count.
// Assumes base, count, mode and mask come from an external register file.
module dma_service_engine
    import dma_svc_pkg::*;
#(
    parameter  int OFF_W  = 16,
    parameter  int SHIFT  = 0,
    localparam int CNT_W  = OFF_W + SHIFT + 1,
    localparam int ADDR_W = HPAGE_USE + PAGE_W + OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pg_wr_i,
    input  logic                 pg_wr_hi_i,
    input  logic [PORT_W-1:0]    pg_wr_port_i,
    input  logic [PAGE_W-1:0]    pg_wr_data_i,
    input  logic                 pg_rd_hi_i,
    input  logic [PORT_W-1:0]    pg_rd_port_i,
    output logic [PAGE_W-1:0]    pg_rd_data_o,
    input  logic [NCH*OFF_W-1:0] base_addr_i,
    input  logic [NCH*OFF_W-1:0] base_cnt_i,
    input  logic [NCH-1:0]       dec_i,
    input  logic [NCH-1:0]       auto_i,
    input  logic [NCH-1:0]       mask_i,
    input  logic [NCH-1:0]       load_i,
    input  logic [NCH-1:0]       hold_i,
    input  logic [NCH-1:0]       release_i,
    output logic                 xfer_o,
    output logic [CH_W-1:0]      xfer_chan_o,
    output logic [ADDR_W-1:0]    xfer_addr_o,
    output logic [NCH-1:0]       tc_o
);

    logic [NCH*PAGE_W-1:0] page_flat;
    logic [NCH*PAGE_W-1:0] hpage_flat;
    logic [NCH-1:0]        want;
    logic [NCH-1:0]        elig;
    logic [NCH-1:0]        grant;
    logic [NCH-1:0]        tc_hit;
    logic [CH_W-1:0]       gidx;
    logic                  gvalid;
    logic [OFF_W-1:0]      cur_a [NCH];
    logic [CNT_W-1:0]      cnt_a [NCH];
    logic [OFF_W-1:0]      off_sel;
    logic [ADDR_W-1:0]     addr_nxt;

    dma_page_regs u_pages (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (pg_wr_i),
        .wr_hi_i   (pg_wr_hi_i),
        .wr_port_i (pg_wr_port_i),
        .wr_data_i (pg_wr_data_i),
        .rd_hi_i   (pg_rd_hi_i),
        .rd_port_i (pg_rd_port_i),
        .rd_data_o (pg_rd_data_o),
        .page_o    (page_flat),
        .hpage_o   (hpage_flat)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dma_chan_state #(.OFF_W(OFF_W), .SHIFT(SHIFT)) u_state (
            .clk         (clk),
            .rst_n       (rst_n),
            .load_i      (load_i[g]),
            .hold_i      (hold_i[g]),
            .release_i   (release_i[g]),
            .serve_i     (grant[g]),
            .auto_i      (auto_i[g]),
            .base_addr_i (base_addr_i[g*OFF_W +: OFF_W]),
            .base_cnt_i  (base_cnt_i[g*OFF_W +: OFF_W]),
            .want_o      (want[g]),
            .cur_o       (cur_a[g]),
            .cnt_o       (cnt_a[g]),
            .tc_hit_o    (tc_hit[g])
        );
    end

    assign elig = want & ~mask_i & ~load_i;

    dma_fixed_arb #(.N(NCH)) u_arb (
        .req_i   (elig),
        .grant_o (grant),
        .idx_o   (gidx),
        .valid_o (gvalid)
    );

    // Form the served channel's offset and full physical address.
    always_comb begin
        off_sel  = dec_i[gidx] ? cur_a[gidx] - cnt_a[gidx][OFF_W-1:0]
                               : cur_a[gidx] + cnt_a[gidx][OFF_W-1:0];
        addr_nxt = {hpage_flat[gidx*PAGE_W +: HPAGE_USE],
                    page_flat[gidx*PAGE_W +: PAGE_W], off_sel};
    end

    // Register the transfer strobe, address and terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_o      <= 1'b0;
            xfer_chan_o <= '0;
            xfer_addr_o <= '0;
            tc_o        <= '0;
        end else begin
            xfer_o <= gvalid;
            tc_o   <= tc_hit;
            if (gvalid) begin
                xfer_chan_o <= gidx;
                xfer_addr_o <= addr_nxt;
            end
        end
    end

    AST_ONE_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));                                                  // R6
    AST_TC_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o != '0) |-> (xfer_o && $onehot0(tc_o)));                      // R9

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
            grant[g] |-> (want[g] && !mask_i[g] && !load_i[g]));           // R6
        AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            (tc_o[g] && !$past(auto_i[g])) |=> !tc_o[g]);                  // R9
    end

endmodule

// File: tb/tb_dma_service_engine.sv
// Scoreboard bench: driver tasks queue expected transfers, monitors pop and compare.
module tb_dma_service_engine;

    typedef struct {
        int          ch;
        logic [30:0] addr;
        logic [3:0]  tc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_wr = 1'b0, pg_wr_hi = 1'b0, pg_rd_hi = 1'b0;
    logic [2:0]  pg_wr_port = '0, pg_rd_port = '0;
    logic [7:0]  pg_wr_data = '0;
    logic [7:0]  pg_rd_data, pg_rd_data_w;
    logic [63:0] base_addr = '0, base_cnt = '0;
    logic [3:0]  dec = '0, autoi = '0, mask = 4'hF, load = '0, hold = '0, rel = '0;
    logic [3:0]  mask_w = 4'hF, load_w = '0, hold_w = '0;
    logic        xfer, xfer_w;
    logic [1:0]  xchan, xchan_w;
    logic [30:0] xaddr, xaddr_w;
    logic [3:0]  tc, tc_w;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];
    exp_t qw[$];
    logic [7:0] pg_m [4];
    logic [7:0] hp_m [4];

    always #4 clk = ~clk;

    dma_service_engine dut (
        .clk(clk), .rst_n(rst_n), .pg_wr_i(pg_wr), .pg_wr_hi_i(pg_wr_hi),
        .pg_wr_port_i(pg_wr_port), .pg_wr_data_i(pg_wr_data), .pg_rd_hi_i(pg_rd_hi),
        .pg_rd_port_i(pg_rd_port), .pg_rd_data_o(pg_rd_data), .base_addr_i(base_addr),
        .base_cnt_i(base_cnt), .dec_i(dec), .auto_i(autoi), .mask_i(mask),
        .load_i(load), .hold_i(hold), .release_i(rel), .xfer_o(xfer),
        .xfer_chan_o(xchan), .xfer_addr_o(xaddr), .tc_o(tc)
    );

    dma_service_engine #(.SHIFT(1)) dut_w (
        .clk(clk), .rst_n(rst_n), .pg_wr_i(pg_wr), .pg_wr_hi_i(pg_wr_hi),
        .pg_wr_port_i(pg_wr_port), .pg_wr_data_i(pg_wr_data), .pg_rd_hi_i(pg_rd_hi),
        .pg_rd_port_i(pg_rd_port), .pg_rd_data_o(pg_rd_data_w), .base_addr_i(base_addr),
        .base_cnt_i(base_cnt), .dec_i(dec), .auto_i(autoi), .mask_i(mask_w),
        .load_i(load_w), .hold_i(hold_w), .release_i(4'h0), .xfer_o(xfer_w),
        .xfer_chan_o(xchan_w), .xfer_addr_o(xaddr_w), .tc_o(tc_w)
    );

    function automatic logic [30:0] mk_addr(int ch, logic [15:0] off);
        return {hp_m[ch][6:0], pg_m[ch], off};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor for the byte controller.
    always @(negedge clk) begin
        if (rst_n && xfer) begin
            if (q.size() == 0) begin
                check(1'b0, "R6 unexpected transfer", {1'b0, xaddr}, 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(xchan == 2'(e.ch), {e.tag, " chan"}, 32'(xchan), 32'(e.ch));
                check(xaddr == e.addr, {e.tag, " addr"}, {1'b0, xaddr}, {1'b0, e.addr});
                check(tc == e.tc, {e.tag, " R9 tc"}, 32'(tc), 32'(e.tc));
            end
        end else if (rst_n && tc != 4'h0) begin
            check(1'b0, "R9 tc without strobe", 32'(tc), 32'h0);
        end
    end

    // Monitor for the word controller.
    always @(negedge clk) begin
        if (rst_n && xfer_w) begin
            if (qw.size() == 0) begin
                check(1'b0, "R11 unexpected word transfer", {1'b0, xaddr_w}, 32'h0);
            end else begin
                exp_t e;
                e = qw.pop_front();
                check(xaddr_w == e.addr, {e.tag, " addr"}, {1'b0, xaddr_w}, {1'b0, e.addr});
                check(tc_w == e.tc, {e.tag, " tc"}, 32'(tc_w), 32'(e.tc));
            end
        end
    end

    task automatic expect_x(int ch, logic [15:0] off, bit last, string tag);
        exp_t e;
        e.ch = ch; e.addr = mk_addr(ch, off);
        e.tc = last ? 4'(1 << ch) : 4'h0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic pg_write(logic [2:0] port, bit hi, logic [7:0] d);
        @(negedge clk);
        pg_wr = 1'b1; pg_wr_port = port; pg_wr_hi = hi; pg_wr_data = d;
        @(negedge clk);
        pg_wr = 1'b0;
    endtask

    task automatic pg_check(logic [2:0] port, bit hi, logic [7:0] exp, string tag);
        @(negedge clk);
        pg_rd_port = port; pg_rd_hi = hi;
        #1;
        check(pg_rd_data == exp, tag, 32'(pg_rd_data), 32'(exp));
    endtask

    task automatic set_base(int ch, logic [15:0] a, logic [15:0] c);
        base_addr[ch*16 +: 16] = a;
        base_cnt[ch*16 +: 16]  = c;
    endtask

    task automatic pulse_load(logic [3:0] m);
        @(negedge clk); load = m;
        @(negedge clk); load = 4'h0;
    endtask

    task automatic pulse_hold(logic [3:0] m);
        @(negedge clk); hold = m;
        @(negedge clk); hold = 4'h0;
    endtask

    task automatic pulse_rel(logic [3:0] m);
        @(negedge clk); rel = m;
        @(negedge clk); rel = 4'h0;
    endtask

    task automatic drain(string tag);
        int n = 0;
        while ((q.size() != 0 || qw.size() != 0) && n < 500) begin
            @(negedge clk);
            n++;
        end
        check(q.size() == 0 && qw.size() == 0, {tag, " queue drained"},
              32'(q.size() + qw.size()), 32'h0);
        repeat (6) @(negedge clk);
    endtask

    // Global watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(xfer == 1'b0 && tc == 4'h0, "R1 idle outputs", {xfer, tc}, 32'h0);
        for (int p = 0; p < 8; p++) begin
            pg_check(3'(p), 1'b0, 8'h00, "R1 page zero");
            pg_check(3'(p), 1'b1, 8'h00, "R1 high page zero");
        end

        // R2 scrambled map: 7->0, 3->1, 1->2, 2->3
        pg_m[0] = 8'h12; hp_m[0] = 8'h83;
        pg_m[1] = 8'h34; hp_m[1] = 8'h05;
        pg_m[2] = 8'h56; hp_m[2] = 8'h7F;
        pg_m[3] = 8'h9A; hp_m[3] = 8'hFF;
        pg_write(3'd7, 1'b0, pg_m[0]); pg_write(3'd7, 1'b1, hp_m[0]);
        pg_write(3'd3, 1'b0, pg_m[1]); pg_write(3'd3, 1'b1, hp_m[1]);
        pg_write(3'd1, 1'b0, pg_m[2]); pg_write(3'd1, 1'b1, hp_m[2]);
        pg_write(3'd2, 1'b0, pg_m[3]); pg_write(3'd2, 1'b1, hp_m[3]);
        // R3 unmapped offsets ignore writes
        pg_write(3'd0, 1'b0, 8'hEE); pg_write(3'd4, 1'b1, 8'hEE);
        pg_write(3'd5, 1'b0, 8'hEE); pg_write(3'd6, 1'b1, 8'hEE);
        pg_check(3'd7, 1'b0, pg_m[0], "R2 page ch0");
        pg_check(3'd3, 1'b0, pg_m[1], "R2 page ch1");
        pg_check(3'd1, 1'b0, pg_m[2], "R2 page ch2");
        pg_check(3'd2, 1'b0, pg_m[3], "R2 page ch3");
        pg_check(3'd7, 1'b1, hp_m[0], "R2 high page ch0");
        pg_check(3'd2, 1'b1, hp_m[3], "R2 high page full 8 bits");
        pg_check(3'd0, 1'b0, 8'h00, "R3 read offset 0");
        pg_check(3'd4, 1'b1, 8'h00, "R3 read offset 4");
        pg_check(3'd5, 1'b0, 8'h00, "R3 read offset 5");
        pg_check(3'd6, 1'b1, 8'h00, "R3 read offset 6");

        // R4 R7 R8 R9: ch0 upward, three bytes
        set_base(0, 16'h0100, 16'd2);
        mask = 4'h0;
        pulse_load(4'b0001);
        for (int k = 0; k < 3; k++) expect_x(0, 16'h0100 + 16'(k), k == 2, "R8 ch0 up");
        pulse_hold(4'b0001);
        drain("R9 ch0 stops after tc");
        // R5 hold on a finished channel restarts it
        for (int k = 0; k < 3; k++) expect_x(0, 16'h0100 + 16'(k), k == 2, "R5 rearm ch0");
        pulse_hold(4'b0001);
        drain("R5 rearm");
        pulse_rel(4'b0001);

        // R8 decrement with wrap below zero on ch1
        dec = 4'b0010;
        set_base(1, 16'h0000, 16'd1);
        pulse_load(4'b0010);
        expect_x(1, 16'h0000, 1'b0, "R8 ch1 down");
        expect_x(1, 16'hFFFF, 1'b1, "R8 ch1 down wrap");
        pulse_hold(4'b0010);
        drain("R8 decrement");
        pulse_rel(4'b0010);
        dec = 4'h0;

        // R6 fixed priority: ch2 before ch3, then R4 high page bit 7 dropped
        set_base(2, 16'h2000, 16'd1);
        set_base(3, 16'h3000, 16'd0);
        pulse_load(4'b1100);
        expect_x(2, 16'h2000, 1'b0, "R6 ch2 first");
        expect_x(2, 16'h2001, 1'b1, "R6 ch2 second");
        expect_x(3, 16'h3000, 1'b1, "R4 ch3 after ch2");
        pulse_hold(4'b1100);
        drain("R6 priority");
        pulse_rel(4'b1100);

        // R6 mask blocks service until cleared
        mask = 4'b0001;
        set_base(0, 16'h0500, 16'd0);
        pulse_load(4'b0001);
        pulse_hold(4'b0001);
        repeat (10) @(negedge clk);
        check(q.size() == 0, "R6 masked idle", 32'(q.size()), 32'h0);
        expect_x(0, 16'h0500, 1'b1, "R6 unmasked ch0");
        mask = 4'h0;
        drain("R6 mask");
        pulse_rel(4'b0001);

        // R5 release clears, and hold beats release in the same cycle
        mask = 4'b0010;
        set_base(1, 16'h0040, 16'd0);
        pulse_load(4'b0010);
        pulse_hold(4'b0010);
        pulse_rel(4'b0010);
        mask = 4'h0;
        repeat (10) @(negedge clk);
        check(!xfer, "R5 released channel idle", 32'(xfer), 32'h0);
        mask = 4'b0010;
        @(negedge clk); hold = 4'b0010; rel = 4'b0010;
        @(negedge clk); hold = 4'h0; rel = 4'h0;
        expect_x(1, 16'h0040, 1'b1, "R5 hold wins");
        mask = 4'h0;
        drain("R5 hold wins");
        pulse_rel(4'b0010);

        // R10 auto-initialise: two full passes on ch3, then masked
        autoi = 4'b1000;
        set_base(3, 16'h0700, 16'd1);
        pulse_load(4'b1000);
        for (int k = 0; k < 4; k++) expect_x(3, 16'h0700 + 16'(k % 2), (k % 2) == 1, "R10 auto");
        pulse_hold(4'b1000);
        repeat (4) @(posedge clk);
        @(negedge clk); mask = 4'b1000;
        drain("R10 auto");
        pulse_rel(4'b1000);
        mask = 4'h0;
        autoi = 4'h0;

        // R11 word controller: base 0x9000 -> 0x2000 after shift and truncation
        set_base(0, 16'h9000, 16'd1);
        mask_w = 4'hE;
        @(negedge clk); load_w = 4'b0001;
        @(negedge clk); load_w = 4'h0;
        begin
            exp_t e;
            e.ch = 0; e.addr = mk_addr(0, 16'h2000); e.tc = 4'h0; e.tag = "R11 word first";
            qw.push_back(e);
            e.addr = mk_addr(0, 16'h2002); e.tc = 4'h1; e.tag = "R11 word tc";
            qw.push_back(e);
        end
        @(negedge clk); hold_w = 4'b0001;
        @(negedge clk); hold_w = 4'h0;
        drain("R11 word");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule